// File: doc/BRIEF.md
# Domain Access Control Checker

This block judges every memory access against a 32-bit domain access control word. The word holds sixteen 2-bit mode fields, one per protection domain. Each access arrives with its own inputs: a 4-bit domain number taken from its translation descriptor, a pass/fail result from a separate permission unit, whether it is a word access, and the low two bits of its address. The block raises `abort` in the same cycle when the access is refused. On the next clock edge it captures the reason and the domain into a fault status register. That register keeps its value until another fault arrives or until a dedicated clear pulse.

There are four domain modes. No-access refuses everything. A reserved code behaves exactly like no-access. Client defers to the external permission result. Manager skips permission checking altogether. An enabled alignment check takes precedence over all of these. When the translation unit is disabled, nothing is checked and nothing aborts.

The access strobe is a plain single-cycle qualifier and has no back-pressure: the block has no ready output and never stalls. Each cycle with `acc_valid` high is one access, and it is judged in that same cycle. All other pins are plain control and status.

Top module: `dac_checker`

## Requirements
- R1: With the translation unit enabled, an access to a domain whose field is 2'b00 (no access) aborts with status code 4'b1001 (domain fault). Domain n uses bits 2n+1:2n of the access control word.
- R2: Field code 2'b10 (reserved) produces exactly the same outcome as 2'b00: an abort with status 4'b1001.
- R3: With field code 2'b01 (client), the access passes when `perm_ok` is 1. When `perm_ok` is 0 it aborts with status 4'b1101 (permission fault).
- R4: With field code 2'b11 (manager), no permission fault is raised, whatever the value of `perm_ok`.
- R5: When `align_chk_en` is 1, a word access (`acc_word`=1) with `acc_addr_lo` not equal to 2'b00 aborts with status 4'b0001. This check outranks the domain and permission checks. Byte accesses, and any access made while the check is disabled, raise no alignment fault.
- R6: When `mmu_en` is 0, `abort` stays 0 whatever the other access inputs are.
- R7: `fsr` holds the status code in bits 3:0 and the faulting domain in bits 7:4. Bit 8 and bits 31:9 read as zero.
- R8: `fsr` takes the new value on the clock edge after a cycle in which `abort` is 1. It does not change after non-aborting cycles.
- R9: Reset clears `fsr` and the access control word to zero. A `fsr_clr` pulse without a fault clears `fsr` on the next edge.
- R10: A `dac_wr_en` pulse loads `dac_wr_data` into the access control word on the clock edge, and accesses from the next cycle use the new word.
- R11: When `fsr_clr` and an aborting access fall in the same cycle, the new fault is captured and the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| dac_wr_en | input | 1 | Write strobe for the access control word |
| dac_wr_data | input | 32 | New access control word |
| mmu_en | input | 1 | Translation unit enabled |
| align_chk_en | input | 1 | Alignment check enabled |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_domain | input | 4 | Domain number of the access |
| acc_word | input | 1 | Access is word-sized |
| acc_addr_lo | input | 2 | Low address bits of the access |
| perm_ok | input | 1 | External permission check passed |
| fsr_clr | input | 1 | Clear the fault status register |
| abort | output | 1 | Access refused this cycle |
| fsr | output | 32 | Fault status register |

## Verification
Two functions can land in the same cycle. First, an alignment fault and a domain fault can both apply to one access. The bench provokes this with a misaligned word access to a no-access domain, and expects status 4'b0001 while the domain number is still recorded. Second, a register clear and a fault capture can coincide. The bench pulses `fsr_clr` together with an aborting access, and expects `fsr` on the next edge to hold the new fault rather than zero.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int NUM_DOMAINS = 16;
  localparam int DOM_W       = $clog2(NUM_DOMAINS);
  localparam int DAC_W       = 2 * NUM_DOMAINS;
  localparam int FSR_W       = 32;

  typedef enum logic [1:0] {
    MODE_NOACC   = 2'b00,
    MODE_CLIENT  = 2'b01,
    MODE_RSVD    = 2'b10,
    MODE_MANAGER = 2'b11
  } dom_mode_e;

  typedef enum logic [3:0] {
    ST_NONE   = 4'b0000,
    ST_ALIGN  = 4'b0001,
    ST_DOMAIN = 4'b1001,
    ST_PERM   = 4'b1101
  } fault_st_e;
endpackage

// File: rtl/dac_field_sel.sv
module dac_field_sel
  import dac_pkg::*;
#(
  parameter int NDOM = NUM_DOMAINS,
  localparam int DW  = $clog2(NDOM)
) (
  input  logic [2*NDOM-1:0] dac_word,
  input  logic [DW-1:0]     dom,
  output dom_mode_e         mode
);
  logic [1:0] fld [NDOM];

  for (genvar g = 0; g < NDOM; g++) begin : g_fld
    assign fld[g] = dac_word[2*g+1 : 2*g];
  end

  assign mode = dom_mode_e'(fld[dom]);
endmodule

// File: rtl/dac_fault_eval.sv
module dac_fault_eval
  import dac_pkg::*;
(
  input  logic      valid,
  input  logic      mmu_en,
  input  logic      align_en,
  input  logic      word,
  input  logic [1:0] addr_lo,
  input  dom_mode_e mode,
  input  logic      perm_ok,
  output logic      abort,
  output fault_st_e status
);
  logic misaligned;
  assign misaligned = align_en && word && (addr_lo != 2'b00);

  always_comb begin
    status = ST_NONE;
    if (misaligned) begin
      status = ST_ALIGN;
    end else begin
      unique case (mode)
        MODE_NOACC, MODE_RSVD: status = ST_DOMAIN;
        MODE_CLIENT:           status = perm_ok ? ST_NONE : ST_PERM;
        MODE_MANAGER:          status = ST_NONE;
        default:               status = ST_NONE;
      endcase
    end
  end

  assign abort = valid && mmu_en && (status != ST_NONE);
endmodule

// File: rtl/dac_fsr_reg.sv
module dac_fsr_reg
  import dac_pkg::*;
#(
  parameter int DW = DOM_W,
  parameter int OW = FSR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  fault_st_e     status,
  input  logic [DW-1:0] dom,
  output logic [OW-1:0] fsr
);
  localparam int CW = 4 + DW;
  logic [CW-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cap_q <= '0;
    else if (load) cap_q <= {dom, status};
    else if (clr)  cap_q <= '0;
  end

  assign fsr = {{(OW-CW){1'b0}}, cap_q};

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> (fsr == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(fsr));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (fsr[3:0] == $past(status)) && (fsr[CW-1:4] == $past(dom)));
endmodule

// File: rtl/dac_checker.sv
module dac_checker
  import dac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dac_wr_en,
  input  logic [31:0] dac_wr_data,
  input  logic        mmu_en,
  input  logic        align_chk_en,
  input  logic        acc_valid,
  input  logic [3:0]  acc_domain,
  input  logic        acc_word,
  input  logic [1:0]  acc_addr_lo,
  input  logic        perm_ok,
  input  logic        fsr_clr,
  output logic        abort,
  output logic [31:0] fsr
);
  logic [DAC_W-1:0] dac_q;
  dom_mode_e        cur_mode;
  fault_st_e        cur_status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_q <= '0;
    else if (dac_wr_en) dac_q <= dac_wr_data;
  end

  dac_field_sel #(.NDOM(NUM_DOMAINS)) u_sel (
    .dac_word (dac_q),
    .dom      (acc_domain),
    .mode     (cur_mode)
  );

  dac_fault_eval u_eval (
    .valid    (acc_valid),
    .mmu_en   (mmu_en),
    .align_en (align_chk_en),
    .word     (acc_word),
    .addr_lo  (acc_addr_lo),
    .mode     (cur_mode),
    .perm_ok  (perm_ok),
    .abort    (abort),
    .status   (cur_status)
  );

  dac_fsr_reg #(.DW(DOM_W), .OW(FSR_W)) u_fsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (abort),
    .clr    (fsr_clr),
    .status (cur_status),
    .dom    (acc_domain),
    .fsr    (fsr)
  );

  a_r6_mmu_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mmu_en |-> !abort);
  a_r4_manager: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_MANAGER) |-> (cur_status != ST_PERM));
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mmu_en && cur_mode == MODE_RSVD) |-> abort);
  a_r5_align_first: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mmu_en && align_chk_en && acc_word && acc_addr_lo != 2'b00)
      |-> (abort && cur_status == ST_ALIGN));
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (fsr[31:8] == '0));
endmodule

// File: tb/dac_checker_test.sv
module dac_checker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dac_wr_en = 1'b0;
  logic [31:0] dac_wr_data = '0;
  logic        mmu_en = 1'b0;
  logic        align_chk_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_domain = '0;
  logic        acc_word = 1'b0;
  logic [1:0]  acc_addr_lo = '0;
  logic        perm_ok = 1'b0;
  logic        fsr_clr = 1'b0;
  logic        abort;
  logic [31:0] fsr;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_fsr = '0;

  always #10 clk = ~clk;

  dac_checker uut (
    .clk(clk), .rst_n(rst_n), .dac_wr_en(dac_wr_en), .dac_wr_data(dac_wr_data),
    .mmu_en(mmu_en), .align_chk_en(align_chk_en), .acc_valid(acc_valid),
    .acc_domain(acc_domain), .acc_word(acc_word), .acc_addr_lo(acc_addr_lo),
    .perm_ok(perm_ok), .fsr_clr(fsr_clr), .abort(abort), .fsr(fsr)
  );

  // {dom[4], mode[2], perm, word, lo[2], align_en, mmu, exp_abort, exp_status[4]}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {4'd3,  2'b00, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 4'b1001}, // R1
    {4'd7,  2'b10, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1001}, // R2
    {4'd0,  2'b01, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 4'b0000}, // R3 pass
    {4'd15, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1101}, // R3 fail
    {4'd9,  2'b11, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 4'b0000}, // R4
    {4'd12, 2'b11, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 4'b0000}, // R4
    {4'd5,  2'b01, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1, 4'b0001}, // R5
    {4'd2,  2'b00, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 4'b0001}, // R5 over domain
    {4'd6,  2'b01, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 4'b1101}, // R5 check off
    {4'd4,  2'b01, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 4'b0000}, // R5 byte
    {4'd8,  2'b00, 1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 4'b0000}, // R6
    {4'd11, 2'b10, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 4'b0000}, // R6
    {4'd1,  2'b00, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 4'b1001}  // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] make_dac(input logic [3:0] d, input logic [1:0] m);
    logic [31:0] w = '0;
    for (int k = 0; k < 16; k++) w[2*k +: 2] = (k == d) ? m : ~m;
    return w;
  endfunction

  task automatic write_dac(input logic [31:0] w);
    @(negedge clk);
    dac_wr_en = 1'b1; dac_wr_data = w;
    @(negedge clk);
    dac_wr_en = 1'b0;
  endtask

  // Drive at negedge, check abort before the edge, fsr after it.
  task automatic access(input string req, input logic [3:0] d, input logic p, input logic w,
                        input logic [1:0] lo, input logic ae, input logic me, input logic clr,
                        input logic ex_ab, input logic [3:0] ex_st);
    acc_valid = 1'b1; acc_domain = d; perm_ok = p; acc_word = w;
    acc_addr_lo = lo; align_chk_en = ae; mmu_en = me; fsr_clr = clr;
    #1;
    check({req, " abort"}, {31'd0, abort}, {31'd0, ex_ab});
    if (ex_ab) exp_fsr = {24'd0, d, ex_st};
    else if (clr) exp_fsr = '0;
    @(negedge clk);
    acc_valid = 1'b0; fsr_clr = 1'b0;
    check({req, " fsr"}, fsr, exp_fsr);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset fsr", fsr, 32'd0);
    check("R9 reset abort idle", {31'd0, abort}, 32'd0);
    // R9/R10: reset word is all no-access; domain 10 faults before any write
    access("R9 reset dac", 4'd10, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1001);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v = VEC[i];
      write_dac(make_dac(v[16:13], v[12:11]));
      access($sformatf("R1-vector%0d", i), v[16:13], v[10], v[9], v[8:7], v[6], v[5],
             1'b0, v[4], v[3:0]);
    end

    // R8: idle cycle with fault-like inputs but no valid leaves fsr unchanged
    write_dac(32'd0);
    acc_domain = 4'd5; mmu_en = 1'b1; perm_ok = 1'b0;
    #1;
    check("R8 no valid abort", {31'd0, abort}, 32'd0);
    @(negedge clk);
    check("R8 hold fsr", fsr, exp_fsr);

    // R10: rewrite word so domain 5 becomes manager, next access passes
    write_dac(32'h0000_0C00);
    access("R10 new word", 4'd5, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000);
    access("R10 neighbour", 4'd4, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1001);

    // R9: clear without fault
    @(negedge clk);
    fsr_clr = 1'b1;
    @(negedge clk);
    fsr_clr = 1'b0; exp_fsr = '0;
    check("R9 clear", fsr, 32'd0);

    // R11: clear and fault together, fault wins; R7 layout
    access("R11 clr+fault", 4'd14, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 4'b1001);
    check("R7 layout", fsr, 32'h0000_00E9);

    // R5 with R2: misaligned word access to reserved domain records alignment
    write_dac(make_dac(4'd13, 2'b10));
    access("R5 align+reserved", 4'd13, 1'b0, 1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule